// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends 8-bit or 9-bit words on a serial data line in step with a shift clock driven by an external master. A host loads words through a one-cycle write strobe into a single holding register. The holding register feeds a transmit shift register, so one word can wait while another is being sent. The block passes the external clock through a synchronizer and finds its edges in the system clock domain. A polarity input decides which edge moves the data line and which edge the master samples on.

Two status outputs report progress. The buffer-empty flag goes high when the holding register can take a new word. The shifter-empty flag goes high when nothing is left to send. An interrupt request is the buffer-empty flag gated by an enable input. The transmitter works only when the mode inputs select synchronous slave transmission. In any other mode it drops its pending data and ignores writes.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when sync_en=1, clk_src_master=0, rx_single_en=0, rx_cont_en=0, port_en=1 and tx_en=1. While it is inactive, a wr_stb is ignored and buf_empty is 0.
- R2: A write to an active block with an empty shifter clears buf_empty on the write edge. On the next clock edge the word moves into the shifter, buf_empty returns to 1 and bit 0 of the word appears on sdo.
- R3: Bits go out least significant bit first. With ck_pol=0 the data changes after a falling edge of ext_sck and holds across the rising edge. With ck_pol=1 the two edges swap roles. The idle level of ext_sck equals ck_pol, so the first edge of a frame is a sampling edge.
- R4: With nine_bit_sel=0 a frame has 8 bits. With nine_bit_sel=1 it has 9 bits, and bit 8 is the ninth_bit value captured on the write edge. Both selections are taken at the write.
- R5: A word written while a frame is shifting stays in the holding register and buf_empty stays 0. On the launch edge that ends the current frame, the word moves into the shifter and buf_empty becomes 1.
- R6: When a frame ends and no word is waiting, sdo returns to its idle level of 1.
- R7: sr_empty is 1 only when no bits are left to shift and no word is held. It goes to 0 on the write edge.
- R8: irq equals buf_empty AND buf_irq_en.
- R9: Leaving the active mode discards both the frame in flight and the held word. sr_empty becomes 1 and sdo becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | Master clock source select (must be 0) |
| rx_single_en | input | 1 | Single receive enable (must be 0) |
| rx_cont_en | input | 1 | Continuous receive enable (must be 0) |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| nine_bit_sel | input | 1 | 1 selects 9-bit frames |
| ninth_bit | input | 1 | Ninth data bit, captured on a write |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Low data bits to write |
| ext_sck | input | 1 | Shift clock from the external master |
| ck_pol | input | 1 | Edge polarity select |
| buf_irq_en | input | 1 | Interrupt enable for buf_empty |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty flag |
| sr_empty | output | 1 | Shifter and holding register empty |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The host writes at most one word while another word is shifting. ck_pol changes only while the block is idle. Each level of ext_sck lasts several system clocks, so every edge passes through the synchronizer. The bench follows these rules. It drives ext_sck with half periods of six cycles. It waits until a frame has finished before changing polarity or width. Its random mix of single-word and back-to-back transactions never writes a third word before the first frame ends.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic {
      LAUNCH_ON_FALL = 1'b0,
      LAUNCH_ON_RISE = 1'b1
   } stx_pol_e;

   function automatic int stx_cnt_bits(input int frame_w);
      return $clog2(frame_w + 1);
   endfunction
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [FRAME_W-1:0] wr_word,
   input  logic               wr_long,
   input  logic               take,
   output logic               valid,
   output logic [FRAME_W-1:0] word,
   output logic               long_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         word   <= '0;
         long_q <= 1'b0;
      end else if (clr) begin
         valid  <= 1'b0;
      end else if (wr) begin
         valid  <= 1'b1;
         word   <= wr_word;
         long_q <= wr_long;
      end else if (take) begin
         valid  <= 1'b0;
      end
   end

   // R5
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !take && !clr) |=> valid);
endmodule

// File: rtl/stx_shift.sv
module stx_shift
   import stx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = DATA_W + 1,
   parameter int CNT_W   = stx_cnt_bits(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               sck_s,
   input  stx_pol_e           pol,
   input  logic               hold_valid,
   input  logic [FRAME_W-1:0] hold_word,
   input  logic               hold_long,
   output logic               take,
   output logic               busy,
   output logic               sdo
);
   logic               sck_d;
   logic               rise, fall, launch;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise   = sck_s & ~sck_d;
   assign fall   = ~sck_s & sck_d;
   assign launch = (pol == LAUNCH_ON_RISE) ? rise : fall;

   assign take = !clr && hold_valid &&
                 ((cnt == '0) || ((cnt == CNT_W'(1)) && launch));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '1;
      end else if (clr) begin
         cnt <= '0;
         sr  <= '1;
      end else if (take) begin
         sr  <= hold_word;
         cnt <= hold_long ? CNT_W'(FRAME_W) : CNT_W'(DATA_W);
      end else if (launch && (cnt != '0)) begin
         sr  <= {1'b1, sr[FRAME_W-1:1]};
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign busy = (cnt != '0);
   assign sdo  = busy ? sr[0] : 1'b1;

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_W));

   // R3
   sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !take && !clr) |=> $stable(sdo));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
   import stx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit NINE_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_en,
   input  logic              clk_src_master,
   input  logic              rx_single_en,
   input  logic              rx_cont_en,
   input  logic              port_en,
   input  logic              tx_en,
   input  logic              nine_bit_sel,
   input  logic              ninth_bit,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ext_sck,
   input  logic              ck_pol,
   input  logic              buf_irq_en,
   output logic              sdo,
   output logic              buf_empty,
   output logic              sr_empty,
   output logic              irq
);
   localparam int FRAME_W = DATA_W + 1;
   localparam int CNT_W   = stx_cnt_bits(FRAME_W);

   if (DATA_W < 1) begin : g_bad_width
      $error("sync_slave_tx: DATA_W must be at least 1");
   end

   logic               act;
   logic               sck_s;
   logic [FRAME_W-1:0] wr_word;
   logic               wr_long;
   logic               hold_valid, hold_long, take, busy;
   logic [FRAME_W-1:0] hold_word;

   assign act = sync_en & ~clk_src_master & ~rx_single_en & ~rx_cont_en
              & port_en & tx_en;

   if (NINE_EN) begin : g_nine
      assign wr_word = {ninth_bit, wr_data};
      assign wr_long = nine_bit_sel;
   end else begin : g_eight
      assign wr_word = {1'b0, wr_data};
      assign wr_long = 1'b0;
   end

   stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ext_sck),
      .q    (sck_s)
   );

   stx_hold #(.FRAME_W(FRAME_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (~act),
      .wr     (wr_stb & act),
      .wr_word(wr_word),
      .wr_long(wr_long),
      .take   (take),
      .valid  (hold_valid),
      .word   (hold_word),
      .long_q (hold_long)
   );

   stx_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (~act),
      .sck_s     (sck_s),
      .pol       (stx_pol_e'(ck_pol)),
      .hold_valid(hold_valid),
      .hold_word (hold_word),
      .hold_long (hold_long),
      .take      (take),
      .busy      (busy),
      .sdo       (sdo)
   );

   assign buf_empty = act & ~hold_valid;
   assign sr_empty  = ~busy & ~hold_valid;
   assign irq       = buf_empty & buf_irq_en;

   // R9
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> sr_empty);

   // R2
   wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && act) |=> !buf_empty);

   // R5
   transfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_valid) && act && $past(act)) |-> busy);

   // R1
   inactive_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && $past(!act)) |-> !hold_valid);
endmodule

// File: tb/sync_slave_tx_bench.sv
module sync_slave_tx_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_en = 1'b0, clk_src_master = 1'b0, rx_single_en = 1'b0;
   logic rx_cont_en = 1'b0, port_en = 1'b0, tx_en = 1'b0;
   logic nine_bit_sel = 1'b0, ninth_bit = 1'b0, wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic ext_sck = 1'b0, ck_pol = 1'b0, buf_irq_en = 1'b0;
   logic sdo, buf_empty, sr_empty, irq;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sync_slave_tx u_sync_slave_tx (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
      .clk_src_master(clk_src_master), .rx_single_en(rx_single_en),
      .rx_cont_en(rx_cont_en), .port_en(port_en), .tx_en(tx_en),
      .nine_bit_sel(nine_bit_sel), .ninth_bit(ninth_bit), .wr_stb(wr_stb),
      .wr_data(wr_data), .ext_sck(ext_sck), .ck_pol(ck_pol),
      .buf_irq_en(buf_irq_en), .sdo(sdo), .buf_empty(buf_empty),
      .sr_empty(sr_empty), .irq(irq)
   );

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [8:0] frame_of(input logic [7:0] d, input logic b9);
      return {b9, d};
   endfunction

   function automatic int len_of(input logic long_sel);
      return long_sel ? 9 : 8;
   endfunction

   task automatic tx_mode();
      sync_en = 1; clk_src_master = 0; rx_single_en = 0; rx_cont_en = 0;
      port_en = 1; tx_en = 1;
   endtask

   task automatic set_pol(input logic p);
      ck_pol = p; ext_sck = p; cyc(8);
   endtask

   task automatic do_write(input logic [7:0] d, input logic b9, input logic long_sel);
      wr_data = d; ninth_bit = b9; nine_bit_sel = long_sel; wr_stb = 1;
      cyc(1);
      wr_stb = 0; ninth_bit = ~b9; wr_data = ~d;
   endtask

   // Shifts one frame out; checks each bit before and after its sampling edge.
   task automatic clock_frame(input logic [8:0] w, input int len, input int be_exp);
      for (int i = 0; i < len; i++) begin
         check("R3 bit before sample", sdo, w[i]);
         ext_sck = ~ck_pol; cyc(6);
         check("R3 bit held across sample", sdo, w[i]);
         if (be_exp >= 0) check("R5 flag held low", buf_empty, be_exp);
         ext_sck = ck_pol; cyc(6);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      cyc(3);
      rst_n = 1;
      cyc(2);
      check("R1 reset buf_empty", buf_empty, 0);
      check("R7 reset sr_empty", sr_empty, 1);
      check("R6 reset sdo", sdo, 1);
      check("R8 reset irq", irq, 0);

      tx_mode(); buf_irq_en = 1; cyc(1);
      check("R1 active buf_empty", buf_empty, 1);
      check("R8 irq set", irq, 1);
      buf_irq_en = 0; cyc(1);
      check("R8 irq masked", irq, 0);

      // R1: receive enable blocks writes
      rx_cont_en = 1; cyc(1);
      do_write(8'h5A, 0, 0); cyc(2);
      check("R1 rx_cont buf_empty", buf_empty, 0);
      check("R1 rx_cont sr_empty", sr_empty, 1);
      check("R1 rx_cont sdo", sdo, 1);
      rx_cont_en = 0; cyc(1);
      check("R1 write ignored", sr_empty, 1);
      check("R1 reenabled", buf_empty, 1);
      clk_src_master = 1; do_write(8'h33, 0, 0); clk_src_master = 0; cyc(1);
      check("R1 master mode ignored", sr_empty, 1);

      // R2, R6: single 8-bit frame, ck_pol=0
      set_pol(0);
      do_write(8'hA5, 0, 0);
      check("R2 write clears", buf_empty, 0);
      check("R7 write clears sr_empty", sr_empty, 0);
      cyc(1);
      check("R2 transfer sets", buf_empty, 1);
      check("R2 bit0 on sdo", sdo, 1);
      clock_frame(frame_of(8'hA5, 0), 8, 1);
      check("R6 idle after frame", sdo, 1);
      check("R7 empty after frame", sr_empty, 1);

      // R4: 9-bit frame, ck_pol=1
      set_pol(1);
      do_write(8'h3C, 1, 1); cyc(1);
      clock_frame(frame_of(8'h3C, 1), 9, 1);
      check("R4 ninth bit frame done", sr_empty, 1);

      // R5: double buffering
      set_pol(0);
      do_write(8'h81, 0, 0); cyc(1);
      do_write(8'h7E, 0, 0);
      check("R5 second held", buf_empty, 0);
      clock_frame(frame_of(8'h81, 0), 8, 0);
      check("R5 flag set on transfer", buf_empty, 1);
      check("R5 shifter busy", sr_empty, 0);
      clock_frame(frame_of(8'h7E, 0), 8, 1);
      check("R7 empty after pair", sr_empty, 1);

      // R9: drop mode mid-frame
      do_write(8'h00, 0, 0); cyc(1);
      do_write(8'hFF, 0, 0);
      ext_sck = 1; cyc(6); ext_sck = 0; cyc(6);
      tx_en = 0; cyc(2);
      check("R9 sr_empty", sr_empty, 1);
      check("R9 sdo idle", sdo, 1);
      tx_en = 1; cyc(2);
      check("R9 held word dropped", sr_empty, 1);
      check("R9 buf_empty back", buf_empty, 1);

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [7:0] d1, d2;
         logic b1, b2, l, p, dbl;
         d1 = 8'($urandom); d2 = 8'($urandom);
         b1 = 1'($urandom); b2 = 1'($urandom);
         l = 1'($urandom); p = 1'($urandom); dbl = 1'($urandom);
         set_pol(p);
         do_write(d1, b1, l); cyc(1);
         if (dbl) begin
            do_write(d2, b2, l);
            clock_frame(frame_of(d1, b1), len_of(l), 0);
            check("R5 random transfer", buf_empty, 1);
            clock_frame(frame_of(d2, b2), len_of(l), 1);
         end else begin
            clock_frame(frame_of(d1, b1), len_of(l), 1);
         end
         check("R4 random frame end", sr_empty, 1);
         check("R6 random idle", sdo, 1);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got 0 expected 1 (timeout)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule